// File: doc/BRIEF.md
# SDRAM Idle Power-Down Controller

This block watches an SDRAM controller for idleness and, once the idle stretch reaches a programmed length, puts the memory into power-down. The low-power mode field must select automatic power-down for this to happen. The block picks the kind of power-down from how urgent refresh is at the moment of entry. If the refresh backlog is below its urgent ("must") level, the block sends the power-down command straight away, and the device drops into active power-down with its banks left open. If the backlog has reached the must level, the block first closes all banks with a precharge-all. It then issues refreshes one by one, each acknowledged by the refresh engine, until the backlog reports that it has fallen to its release level. Only after that does it send the power-down command, so the device enters precharge power-down.

CKE stays low for as long as the device is in power-down. The memory clock enable stays asserted the whole time, so the clock keeps running. A new access request wakes the device. CKE rises on the next edge, and a busy flag then covers a programmable exit delay before the controller may issue commands again. A two-bit status output reports the current power-down kind.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: With `lp_mode` equal to 4 and a non-zero threshold T, `pd_cmd` pulses on the (T+1)th rising edge after `ctrl_idle` goes high. With no precharge, the pulse comes on exactly that edge.
- R2: If `ref_must` is low when the idle threshold is reached, no `pre_all_cmd` and no `ref_cmd` is issued before `pd_cmd`, and `pd_status` reads 1 (active power-down).
- R3: If `ref_must` is high when the threshold is reached, the block issues one `pre_all_cmd` and then one `ref_cmd` per refresh. It waits for `ref_done` before the next check of `ref_release`, and issues `pd_cmd` once `ref_release` is high. With N refreshes needed, `pd_cmd` comes on edge T+3+3N, and `pd_status` then reads 2 (precharge power-down).
- R4: `cke` is low on exactly the cycles in which `pd_status` is non-zero. `cke` stays low for the whole power-down stay. `pd_status` encodes 0 as not in power-down, 1 as active power-down and 2 as precharge power-down. It never reads 3.
- R5: `mem_clk_en` stays 1 in every state, including power-down.
- R6: A cycle with `ctrl_idle` low clears the idle count, so the full T+1 cycles are counted again from the next idle cycle.
- R7: A threshold of 0 disables automatic entry.
- R8: When `lp_mode` is not 4, nothing counts toward entry. A change away from 4 during the countdown clears the count, so a later return to 4 starts the count from zero.
- R9: `acc_req` while in power-down raises `cke` on the next edge and sets `pd_status` to 0. It also raises `busy`, which stays high for `exit_delay`+1 cycles.
- R10: `pre_all_cmd`, `ref_cmd` and `pd_cmd` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DDR clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_idle | input | 1 | Controller has no work this cycle |
| acc_req | input | 1 | New access request pending (wake-up) |
| lp_mode | input | 3 | Low-power mode field; 4 selects automatic power-down |
| pd_idle_thresh | input | 8 | Idle cycles before entry; 0 disables |
| exit_delay | input | 4 | Extra busy cycles after wake-up |
| ref_must | input | 1 | Refresh backlog at or above the must level |
| ref_release | input | 1 | Refresh backlog at or below the release level |
| ref_done | input | 1 | Refresh engine finished the requested refresh |
| pre_all_cmd | output | 1 | Precharge-all command pulse |
| ref_cmd | output | 1 | Refresh command pulse |
| pd_cmd | output | 1 | Power-down entry command pulse |
| cke | output | 1 | Clock-enable level to the SDRAM |
| mem_clk_en | output | 1 | Memory clock enable, held high |
| pd_status | output | 2 | 0 none, 1 active, 2 precharge power-down |
| busy | output | 1 | Exit delay in progress |

## Verification
On every cycle the assertions check these rules: CKE against the status code, that each falling CKE follows a power-down command, that the command pulses are exclusive and single-cycle, and that a request during power-down raises CKE and busy on the next edge. The exact entry edge for both kinds of power-down can only be shown by the bench scenarios. So can the refresh count before precharge power-down, the clearing of the count by an idle gap or a mode change, the disable by a zero threshold, and the length of the busy window.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;
  localparam int unsigned MODE_W      = 3;
  localparam int unsigned LP_AUTO_PD  = 4;

  typedef enum logic [1:0] {
    PD_NONE  = 2'd0,
    PD_ACTIVE = 2'd1,
    PD_PRECH = 2'd2
  } pd_kind_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_PRE,
    ST_CHK,
    ST_REF,
    ST_RWAIT,
    ST_ENTER,
    ST_PD,
    ST_EXIT
  } pd_state_e;
endpackage

// File: rtl/pd_idle_counter.sv
module pd_idle_counter #(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             idle,
  input  logic             mode_ok,
  input  logic [THR_W-1:0] thresh,
  output logic             expire
);
  logic [THR_W-1:0] cnt;
  logic             counting;

  assign counting = arm && idle && mode_ok && (thresh != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!counting)  cnt <= '0;
    else if (cnt < thresh) cnt <= cnt + 1'b1;
  end

  assign expire = counting && (cnt >= thresh);
endmodule

// File: rtl/pd_exit_timer.sv
module pd_exit_timer #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DLY_W-1:0] delay,
  output logic             done
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!active)    cnt <= '0;
    else if (cnt < delay) cnt <= cnt + 1'b1;
  end

  assign done = active && (cnt >= delay);
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import sdram_pd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       must,
  input  logic       release_ok,
  input  logic       ref_done,
  input  logic       acc_req,
  input  logic       exit_done,
  output logic       arm,
  output logic       exit_active,
  output logic       pre_all_cmd,
  output logic       ref_cmd,
  output logic       pd_cmd,
  output logic       cke,
  output logic       busy,
  output logic [1:0] pd_status
);
  pd_state_e state, nxt;
  pd_kind_e  kind;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:   if (expire) nxt = must ? ST_PRE : ST_ENTER;
      ST_PRE:   nxt = ST_CHK;
      ST_CHK:   nxt = release_ok ? ST_ENTER : ST_REF;
      ST_REF:   nxt = ST_RWAIT;
      ST_RWAIT: if (ref_done) nxt = ST_CHK;
      ST_ENTER: nxt = ST_PD;
      ST_PD:    if (acc_req) nxt = ST_EXIT;
      ST_EXIT:  if (exit_done) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_RUN;
      kind  <= PD_ACTIVE;
    end else begin
      state <= nxt;
      if (state == ST_RUN && expire)
        kind <= must ? PD_PRECH : PD_ACTIVE;
    end
  end

  assign arm         = (state == ST_RUN);
  assign exit_active = (state == ST_EXIT);
  assign pre_all_cmd = (state == ST_PRE);
  assign ref_cmd     = (state == ST_REF);
  assign pd_cmd      = (state == ST_ENTER);
  assign cke         = (state != ST_PD);
  assign busy        = (state == ST_EXIT);
  assign pd_status   = (state == ST_PD) ? kind : PD_NONE;
endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
  import sdram_pd_pkg::*;
#(
  parameter int unsigned THR_W = 8,
  parameter int unsigned DLY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_idle,
  input  logic              acc_req,
  input  logic [MODE_W-1:0] lp_mode,
  input  logic [THR_W-1:0]  pd_idle_thresh,
  input  logic [DLY_W-1:0]  exit_delay,
  input  logic              ref_must,
  input  logic              ref_release,
  input  logic              ref_done,
  output logic              pre_all_cmd,
  output logic              ref_cmd,
  output logic              pd_cmd,
  output logic              cke,
  output logic              mem_clk_en,
  output logic [1:0]        pd_status,
  output logic              busy
);
  logic arm, expire, exit_active, exit_done, mode_ok;

  assign mode_ok = (lp_mode == MODE_W'(LP_AUTO_PD));

  pd_idle_counter #(.THR_W(THR_W)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .idle    (ctrl_idle),
    .mode_ok (mode_ok),
    .thresh  (pd_idle_thresh),
    .expire  (expire)
  );

  pd_exit_timer #(.DLY_W(DLY_W)) u_exit (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (exit_active),
    .delay  (exit_delay),
    .done   (exit_done)
  );

  pd_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire      (expire),
    .must        (ref_must),
    .release_ok  (ref_release),
    .ref_done    (ref_done),
    .acc_req     (acc_req),
    .exit_done   (exit_done),
    .arm         (arm),
    .exit_active (exit_active),
    .pre_all_cmd (pre_all_cmd),
    .ref_cmd     (ref_cmd),
    .pd_cmd      (pd_cmd),
    .cke         (cke),
    .busy        (busy),
    .pd_status   (pd_status)
  );

  // The memory clock is never gated, in power-down or otherwise.
  assign mem_clk_en = 1'b1;
endmodule

// File: rtl/sdram_pd_ctrl_sva.sv
module sdram_pd_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_req,
  input logic       pre_all_cmd,
  input logic       ref_cmd,
  input logic       pd_cmd,
  input logic       cke,
  input logic       busy,
  input logic [1:0] pd_status
);
  a_r4_cke_low_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_status != 2'd0) |-> !cke);

  a_r4_status_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (pd_status != 2'd0));

  a_r4_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    pd_status != 2'd3);

  a_r2_fall_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(pd_cmd));

  a_r10_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pre_all_cmd, ref_cmd, pd_cmd}));

  a_r10_pd_single: assert property (@(posedge clk) disable iff (!rst_n)
    pd_cmd |=> !pd_cmd);

  a_r10_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_cmd |=> !pre_all_cmd);

  a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && acc_req) |=> (cke && busy && pd_status == 2'd0));
endmodule

bind sdram_pd_ctrl sdram_pd_ctrl_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_req     (acc_req),
  .pre_all_cmd (pre_all_cmd),
  .ref_cmd     (ref_cmd),
  .pd_cmd      (pd_cmd),
  .cke         (cke),
  .busy        (busy),
  .pd_status   (pd_status)
);

// File: tb/sdram_pd_ctrl_test.sv
module sdram_pd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_idle = 1'b0, acc_req = 1'b0, ref_must = 1'b0, ref_done = 1'b0;
  logic [2:0] lp_mode = 3'd4;
  logic [7:0] thresh = 8'd0;
  logic [3:0] exit_delay = 4'd3;
  logic       pre_all_cmd, ref_cmd, pd_cmd, cke, mem_clk_en, busy;
  logic [1:0] pd_status;
  int         refs_left = 0;
  logic       ref_release;

  int n_chk = 0, n_bad = 0;
  int first_pd, n_pre, n_ref;
  bit entered;

  assign ref_release = (refs_left == 0);

  always #4 clk = ~clk;

  sdram_pd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctrl_idle(ctrl_idle), .acc_req(acc_req),
    .lp_mode(lp_mode), .pd_idle_thresh(thresh), .exit_delay(exit_delay),
    .ref_must(ref_must), .ref_release(ref_release), .ref_done(ref_done),
    .pre_all_cmd(pre_all_cmd), .ref_cmd(ref_cmd), .pd_cmd(pd_cmd),
    .cke(cke), .mem_clk_en(mem_clk_en), .pd_status(pd_status), .busy(busy)
  );

  typedef struct packed {
    logic [7:0] thr;
    logic       must;
    logic [3:0] refs;
    logic [1:0] kind;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{thr: 8'd5, must: 1'b0, refs: 4'd0, kind: 2'd1},
    '{thr: 8'd1, must: 1'b0, refs: 4'd0, kind: 2'd1},
    '{thr: 8'd3, must: 1'b1, refs: 4'd2, kind: 2'd2},
    '{thr: 8'd7, must: 1'b1, refs: 4'd1, kind: 2'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Caller has just set inputs at a falling edge; count edges from there.
  task automatic run_entry(input int limit);
    bit done_next = 0;
    first_pd = -1; n_pre = 0; n_ref = 0; entered = 0;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      ref_done = done_next;
      if (done_next && refs_left > 0) refs_left--;
      done_next = ref_cmd;
      if (pre_all_cmd) n_pre++;
      if (ref_cmd) n_ref++;
      if (pd_cmd && first_pd < 0) first_pd = n;
      if (!cke) begin entered = 1; break; end
    end
    ref_done = 0;
  endtask

  task automatic wake_and_check(input string tag);
    int b;
    @(negedge clk);
    acc_req = 1; ctrl_idle = 0;
    @(negedge clk);
    acc_req = 0;
    chk(cke == 1'b1, "R9 cke high after request", cke, 1);
    chk(pd_status == 2'd0, "R9 status cleared", pd_status, 0);
    b = 0;
    for (int k = 0; k < 40 && busy; k++) begin b++; @(negedge clk); end
    chk(b == int'(exit_delay) + 1, {"R9 busy length ", tag}, b, int'(exit_delay) + 1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cke == 1'b1, "R4 reset cke", cke, 1);
    chk(pd_status == 2'd0, "R4 reset status", pd_status, 0);
    chk({pre_all_cmd, ref_cmd, pd_cmd, busy} == 4'b0, "R10 reset commands",
        {pre_all_cmd, ref_cmd, pd_cmd, busy}, 0);

    // Vector table: both kinds of entry, then wake-up.
    foreach (VECS[i]) begin
      @(negedge clk);
      thresh = VECS[i].thr; ref_must = VECS[i].must; refs_left = VECS[i].refs;
      lp_mode = 3'd4; ctrl_idle = 1;
      run_entry(300);
      chk(entered, "R1 entry happened", entered, 1);
      if (VECS[i].must) begin
        chk(first_pd == VECS[i].thr + 3 + 3 * VECS[i].refs, "R3 entry edge",
            first_pd, VECS[i].thr + 3 + 3 * VECS[i].refs);
        chk(n_pre == 1, "R3 one precharge", n_pre, 1);
        chk(n_ref == VECS[i].refs, "R3 refresh count", n_ref, VECS[i].refs);
      end else begin
        chk(first_pd == VECS[i].thr + 1, "R1 entry edge", first_pd, VECS[i].thr + 1);
        chk(n_pre == 0 && n_ref == 0, "R2 no precharge or refresh", n_pre + n_ref, 0);
      end
      ref_must = 0;
      chk(pd_status == VECS[i].kind, "R2/R3 status kind", pd_status, VECS[i].kind);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!cke && pd_status == VECS[i].kind, "R4 cke held low", cke, 0);
        chk(mem_clk_en, "R5 clock enabled in power-down", mem_clk_en, 1);
      end
      exit_delay = 4'(i + 1);
      wake_and_check($sformatf("vec%0d", i));
    end

    // R7: zero threshold never enters.
    @(negedge clk);
    thresh = 0; ctrl_idle = 1;
    run_entry(80);
    chk(!entered && first_pd < 0, "R7 zero threshold", entered, 0);

    // R8: mode other than 4 never enters.
    @(negedge clk);
    thresh = 4; lp_mode = 3'd3;
    run_entry(80);
    chk(!entered && first_pd < 0, "R8 mode not auto", entered, 0);

    // R8: mode leaves 4 mid-countdown, count restarts.
    @(negedge clk);
    ctrl_idle = 0;
    @(negedge clk);
    thresh = 8; lp_mode = 3'd4; ctrl_idle = 1;
    repeat (5) @(negedge clk);
    lp_mode = 3'd2;
    @(negedge clk);
    lp_mode = 3'd4;
    run_entry(100);
    chk(first_pd == 9, "R8 count cleared by mode change", first_pd, 9);
    wake_and_check("r8");

    // R6: idle gap restarts the count.
    @(negedge clk);
    thresh = 6; ctrl_idle = 1;
    repeat (5) @(negedge clk);
    ctrl_idle = 0;
    @(negedge clk);
    ctrl_idle = 1;
    run_entry(100);
    chk(first_pd == 7, "R6 count cleared by idle gap", first_pd, 7);
    chk(mem_clk_en, "R5 clock enabled", mem_clk_en, 1);
    wake_and_check("r6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule